// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns the header of an address-channel burst (start address, beat size, burst kind, beat count) into the byte address of every beat. The start address is aligned down to the beat size. The block then holds, steps or wraps that address once per accepted beat, according to the burst kind. It also derives the wrap boundary mask from the beat size and the beat count, and presents a per-burst wrap descriptor for the packet that carries the beat.

Beats arrive with a valid flag and with start-of-packet and end-of-packet qualifiers. A downstream ready flag decides whether a beat is taken. The parameter `STEP_EN` picks the variant:

- With `STEP_EN` = 1, a small registered sequencer keeps the address of the next beat.
- With `STEP_EN` = 0, the block is purely combinational. It returns the aligned start address together with its alignment mask, and the beat qualifiers have no effect.

Top module: `burst_addr_gen`

## Requirements
- R1: `burst_kind` is decoded as 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping. The code 2'b11 is reserved and behaves exactly like incrementing.
- R2: `align_mask` equals the complement of (2^`beat_size` − 1). On a first beat, `out_addr` is `start_addr` with its low `beat_size` bits cleared.
- R3: The wrap boundary is a `WRAP_W`−1 bit mask. Bit i is one when i < `beat_size` + ceil(log2(`burst_len`+1)).
- R4: `out_wrap` is all ones for incrementing and reserved bursts. For wrapping bursts it is the boundary mask of R3 with the top bit zero. For fixed bursts it is 2^`beat_size` − 1, truncated to `WRAP_W` bits.
- R5: In a fixed burst, every beat carries the address of the first beat.
- R6: In an incrementing burst, each accepted beat adds 2^`beat_size` to the address of the following beat.
- R7: In a wrapping burst, the address bits above the boundary mask stay as they are. The bits under the mask advance by 2^`beat_size` modulo the boundary, so a burst that starts mid-boundary wraps back to the boundary base.
- R8: A beat is accepted only when `in_valid` and `out_ready` are both high. A stalled beat shows the same address again on the following cycle.
- R9: A beat is a first beat when `in_sop` is high, or when the previous accepted beat carried `in_eop`. A first beat takes its address from `start_addr`.
- R10: The active-low asynchronous reset `rst_n` clears the held state. The next beat after reset is a first beat even when `in_sop` is low.
- R11: With `STEP_EN` = 0, `out_addr` is always the aligned start address, whatever the beat qualifiers and the history are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A beat is presented |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| out_ready | input | 1 | Downstream takes the beat |
| start_addr | input | ADDR_W | Burst start address |
| beat_size | input | 3 | log2 of bytes per beat |
| burst_kind | input | 2 | Burst kind code (R1) |
| burst_len | input | LEN_W | Beats in burst minus one |
| out_addr | output | ADDR_W | Address of the current beat |
| align_mask | output | ADDR_W | Size alignment mask |
| out_wrap | output | WRAP_W | Wrap descriptor (R4) |

## Verification
All three outputs are combinational from the inputs and the held state, so each is due in the same cycle as the beat that shows it. The effect of an accepted beat shows up one clock edge later, as the address of the next beat. The bench drives each beat on the falling edge and samples the outputs 2 ns later, before the rising edge. It then updates its reference model at the rising edge, but only when the beat was accepted. A reset that lands mid-burst is checked on the first beat after release.

// File: rtl/bag_pkg.sv
`timescale 1ns/1ps
package bag_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

    // smallest k such that 2^k >= v
    function automatic int unsigned ceil_log2(input int unsigned v);
        int unsigned r;
        r = 0;
        for (int k = 0; k < 32; k++) begin
            if ((64'd1 << k) < 64'(v)) r = k + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bag_align.sv
`timescale 1ns/1ps
module bag_align #(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        beat_size,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] aligned,
    output logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] step
);
    logic [ADDR_W-1:0] low_bits;

    always_comb begin
        step     = ADDR_W'(1) << beat_size;
        low_bits = step - ADDR_W'(1);
        mask     = ~low_bits;
        aligned  = start_addr & mask;
    end
endmodule

// File: rtl/bag_wrap_calc.sv
`timescale 1ns/1ps
module bag_wrap_calc
    import bag_pkg::*;
#(
    parameter int LEN_W  = 4,
    parameter int WRAP_W = 8
) (
    input  logic [2:0]        beat_size,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [1:0]        burst_kind,
    output logic [WRAP_W-2:0] boundary,
    output logic [WRAP_W-1:0] wrap_val
);
    localparam int BND_W = WRAP_W - 1;

    logic [31:0] span_w;
    logic [31:0] fixed_span;

    always_comb begin
        span_w     = 32'(beat_size) + ceil_log2(32'(burst_len) + 32'd1);
        fixed_span = (32'd1 << beat_size) - 32'd1;
    end

    for (genvar i = 0; i < BND_W; i++) begin : g_bnd
        assign boundary[i] = (span_w > 32'(i));
    end

    always_comb begin
        case (burst_kind_e'(burst_kind))
            BK_WRAP:  wrap_val = {1'b0, boundary};
            BK_FIXED: wrap_val = fixed_span[WRAP_W-1:0];
            default:  wrap_val = {WRAP_W{1'b1}};
        endcase
    end
endmodule

// File: rtl/bag_seq.sv
`timescale 1ns/1ps
module bag_seq
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [1:0]        burst_kind,
    input  logic [ADDR_W-1:0] aligned,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] cur_addr
);
    typedef struct packed {
        logic              open;
        logic [ADDR_W-1:0] addr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic              first;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] nxt;

    always_comb begin
        first    = in_sop || !st_q.open;
        cur_addr = first ? aligned : st_q.addr;
        sum      = cur_addr + step;
        case (burst_kind_e'(burst_kind))
            BK_FIXED: nxt = cur_addr;
            BK_WRAP:  nxt = (cur_addr & ~wrap_mask) | (sum & wrap_mask);
            default:  nxt = sum;
        endcase
        st_d = st_q;
        if (accept) begin
            st_d.open = !in_eop;
            st_d.addr = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 4,
    parameter int WRAP_W  = 8,
    parameter bit STEP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              out_ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        beat_size,
    input  logic [1:0]        burst_kind,
    input  logic [LEN_W-1:0]  burst_len,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] align_mask,
    output logic [WRAP_W-1:0] out_wrap
);
    localparam int BND_W = WRAP_W - 1;

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] step;
    logic [BND_W-1:0]  boundary;
    logic [ADDR_W-1:0] wrap_mask;

    bag_align #(.ADDR_W(ADDR_W)) u_align (
        .beat_size (beat_size),
        .start_addr(start_addr),
        .aligned   (aligned),
        .mask      (align_mask),
        .step      (step)
    );

    bag_wrap_calc #(.LEN_W(LEN_W), .WRAP_W(WRAP_W)) u_wrap (
        .beat_size (beat_size),
        .burst_len (burst_len),
        .burst_kind(burst_kind),
        .boundary  (boundary),
        .wrap_val  (out_wrap)
    );

    assign wrap_mask = {{(ADDR_W-BND_W){1'b0}}, boundary};

    if (STEP_EN) begin : g_step
        bag_seq #(.ADDR_W(ADDR_W)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept    (in_valid && out_ready),
            .in_sop    (in_sop),
            .in_eop    (in_eop),
            .burst_kind(burst_kind),
            .aligned   (aligned),
            .step      (step),
            .wrap_mask (wrap_mask),
            .cur_addr  (out_addr)
        );
    end else begin : g_comb
        assign out_addr = aligned;
    end
endmodule

// File: rtl/bag_checker.sv
`timescale 1ns/1ps
module bag_checker #(
    parameter int ADDR_W  = 32,
    parameter int WRAP_W  = 8,
    parameter bit STEP_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic              in_eop,
    input logic              out_ready,
    input logic [2:0]        beat_size,
    input logic [1:0]        burst_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] align_mask,
    input logic [WRAP_W-1:0] out_wrap
);
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((out_addr & ~align_mask) == '0));

    p_incr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_kind[0] == 1'b1) |-> (out_wrap == {WRAP_W{1'b1}}));

    p_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_kind == 2'b10) |-> !out_wrap[WRAP_W-1]);

    if (STEP_EN) begin : g_seq_chk
        p_fixed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && out_ready && !in_eop && burst_kind == 2'b00)
            |=> (!in_valid || in_sop || out_addr == $past(out_addr)));

        p_incr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && out_ready && !in_eop && burst_kind[0])
            |=> (!in_valid || in_sop ||
                 out_addr == $past(out_addr) + (ADDR_W'(1) << $past(beat_size))));

        p_wrap_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && out_ready && !in_eop && burst_kind == 2'b10)
            |=> (!in_valid || in_sop ||
                 (out_addr & ~ADDR_W'($past(out_wrap))) ==
                 ($past(out_addr) & ~ADDR_W'($past(out_wrap)))));

        p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !out_ready && !in_sop)
            |=> (!in_valid || in_sop || $changed(beat_size) || $changed(burst_kind)
                 || $stable(out_addr)));
    end
endmodule

bind burst_addr_gen bag_checker #(
    .ADDR_W (ADDR_W),
    .WRAP_W (WRAP_W),
    .STEP_EN(STEP_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_ready (out_ready),
    .beat_size (beat_size),
    .burst_kind(burst_kind),
    .out_addr  (out_addr),
    .align_mask(align_mask),
    .out_wrap  (out_wrap)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
    localparam int AW = 32;
    localparam int LW = 4;
    localparam int WW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [2:0]    beat_size = '0;
    logic [1:0]    burst_kind = '0;
    logic [LW-1:0] burst_len = '0;
    logic [AW-1:0] out_addr, align_mask, c_addr, c_mask;
    logic [WW-1:0] out_wrap, c_wrap;

    int n_checks = 0;
    int n_fail = 0;
    bit m_first = 1'b1;
    logic [AW-1:0] m_addr = '0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .WRAP_W(WW), .STEP_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .out_ready(out_ready), .start_addr(start_addr), .beat_size(beat_size),
        .burst_kind(burst_kind), .burst_len(burst_len), .out_addr(out_addr),
        .align_mask(align_mask), .out_wrap(out_wrap));

    burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .WRAP_W(WW), .STEP_EN(1'b0)) u_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .out_ready(out_ready), .start_addr(start_addr), .beat_size(beat_size),
        .burst_kind(burst_kind), .burst_len(burst_len), .out_addr(c_addr),
        .align_mask(c_mask), .out_wrap(c_wrap));

    function automatic logic [AW-1:0] f_align(input logic [AW-1:0] a, input logic [2:0] s);
        return a & ~((AW'(1) << s) - AW'(1));
    endfunction

    function automatic logic [WW-2:0] f_bnd(input logic [2:0] s, input logic [LW-1:0] l);
        int w;
        int lg;
        logic [WW-2:0] m;
        lg = 0;
        while ((1 << lg) < (int'(l) + 1)) lg++;
        w = int'(s) + lg;
        m = '0;
        for (int i = 0; i < WW - 1; i++) if (w > i) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [WW-1:0] f_wrapval(input logic [1:0] k, input logic [2:0] s,
                                                 input logic [LW-1:0] l);
        logic [31:0] f;
        f = (32'd1 << s) - 32'd1;
        if (k == 2'b10) return {1'b0, f_bnd(s, l)};
        if (k == 2'b00) return f[WW-1:0];
        return {WW{1'b1}};
    endfunction

    function automatic logic [AW-1:0] f_next(input logic [1:0] k, input logic [AW-1:0] a,
                                              input logic [2:0] s, input logic [LW-1:0] l);
        logic [AW-1:0] st, m;
        st = AW'(1) << s;
        m  = AW'(f_bnd(s, l));
        if (k == 2'b00) return a;
        if (k == 2'b10) return (a & ~m) | ((a + st) & m);
        return a + st;
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_burst(input logic [1:0] k, input logic [2:0] s,
                             input logic [LW-1:0] l, input logic [AW-1:0] a);
        @(negedge clk);
        in_valid = 1'b0;
        burst_kind = k; beat_size = s; burst_len = l; start_addr = a;
    endtask

    task automatic drive_beat(input logic sop, input logic eop, input logic rdy,
                              input string tag, output logic [AW-1:0] seen);
        logic [AW-1:0] exp;
        bit first;
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; out_ready = rdy;
        #2;
        first = m_first || sop;
        exp = first ? f_align(start_addr, beat_size) : m_addr;
        seen = out_addr;
        chk(first ? {tag, " R9 first beat"} : tag, out_addr, exp);
        chk("R2 align mask", align_mask, ~((AW'(1) << beat_size) - AW'(1)));
        chk(burst_kind == 2'b10 ? "R3 wrap boundary" : "R4 wrap descriptor",
            AW'(out_wrap), AW'(f_wrapval(burst_kind, beat_size, burst_len)));
        chk("R11 combinational variant", c_addr, f_align(start_addr, beat_size));
        @(posedge clk);
        if (rdy) begin
            m_addr = f_next(burst_kind, exp, beat_size, burst_len);
            m_first = eop;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        out_ready = 1'($urandom % 2);
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'b00: return "R5 fixed";
            2'b01: return "R6 incrementing";
            2'b10: return "R7 wrapping";
            default: return "R1 reserved as incrementing";
        endcase
    endfunction

    task automatic run_burst(input logic [1:0] k, input logic [2:0] s,
                             input logic [LW-1:0] l, input logic [AW-1:0] a);
        logic [AW-1:0] seen;
        set_burst(k, s, l, a);
        for (int b = 0; b <= int'(l); b++) begin
            if ($urandom % 5 == 0) idle();
            while ($urandom % 4 == 0)
                drive_beat(b == 0, b == int'(l), 1'b0, "R8 stalled beat", seen);
            drive_beat(b == 0, b == int'(l), 1'b1, kind_tag(k), seen);
        end
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] seen;
        logic [AW-1:0] wexp[4];
        void'($urandom(32'd2024));

        // R10: right after reset, no sop, the beat is a first beat
        set_burst(2'b01, 3'd2, 4'd3, 32'h0000_0107);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive_beat(1'b0, 1'b0, 1'b0, "R10 reset state", seen);
        chk("R10 reset state address", seen, 32'h0000_0104);
        idle();

        // R7: wrapping burst starting mid-boundary, 4 beats of 4 bytes
        wexp[0] = 32'h1008; wexp[1] = 32'h100C; wexp[2] = 32'h1000; wexp[3] = 32'h1004;
        set_burst(2'b10, 3'd2, 4'd3, 32'h0000_100A);
        for (int b = 0; b < 4; b++) begin
            drive_beat(b == 0, b == 3, 1'b1, "R7 wrapping", seen);
            chk("R7 mid-boundary wrap", seen, wexp[b]);
        end
        chk("R3 boundary size2 len3", AW'(out_wrap), 32'h0000_000F);

        // R5: fixed burst keeps address
        set_burst(2'b00, 3'd3, 4'd2, 32'h0000_2013);
        for (int b = 0; b < 3; b++) begin
            drive_beat(b == 0, b == 2, 1'b1, "R5 fixed", seen);
            chk("R5 fixed address", seen, 32'h0000_2010);
        end

        // R9: sop restarts mid-burst; eop followed by a beat without sop is first
        set_burst(2'b01, 3'd0, 4'd7, 32'h0000_0040);
        drive_beat(1'b1, 1'b0, 1'b1, "R6 incrementing", seen);
        drive_beat(1'b0, 1'b0, 1'b1, "R6 incrementing", seen);
        chk("R6 second beat", seen, 32'h0000_0041);
        drive_beat(1'b1, 1'b0, 1'b1, "R9 restart", seen);
        chk("R9 restart on sop", seen, 32'h0000_0040);
        drive_beat(1'b0, 1'b1, 1'b1, "R6 incrementing", seen);
        set_burst(2'b01, 3'd1, 4'd1, 32'h0000_0300);
        drive_beat(1'b0, 1'b0, 1'b1, "R9 after eop", seen);
        chk("R9 after eop without sop", seen, 32'h0000_0300);

        // R10: reset in the middle of a burst
        drive_beat(1'b0, 1'b0, 1'b1, "R6 incrementing", seen);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        m_first = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        drive_beat(1'b0, 1'b1, 1'b1, "R10 after mid-burst reset", seen);
        chk("R10 mid-burst reset", seen, 32'h0000_0300);

        // random bursts over all kinds, sizes and lengths
        for (int n = 0; n < 60; n++) begin
            logic [1:0] k;
            logic [LW-1:0] l;
            k = 2'($urandom % 4);
            l = LW'($urandom % 16);
            if (k == 2'b10) l = LW'((1 << ($urandom % 5)) - 1);
            run_burst(k, 3'($urandom % 8), l, $urandom);
        end
        for (int l = 0; l < 16; l++) run_burst(2'b01, 3'd2, LW'(l), 32'h0000_5000 + 32'(l));

        idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule